// File: doc/BRIEF.md
# Body-Bias Regulator Transition Sequencer

This block sequences operating-mode changes of an on-die body-bias regulator when the supply operating point of a core moves. Software programs two registers: a control word that turns the regulator on, states which bias types are permitted while active, and holds a settling wait count, and a setup word that names the target speed class and carries a request bit. Setting the request bit starts a transition. The block drives the regulator into bypass, forward bias or reverse bias, depending on the class and the permissions.

After the mode is driven, the block waits out a settling window. The window is counted in ticks of eight reference clocks. When the window ends, the block updates the reported regulator status, drops its in-transition indication and raises a sticky done flag. Software clears the flag by writing a one to it. A third register holds that flag. The bus fabric and the analog regulator sit outside the block.

Top module: `bbias_seq_ctrl`

## Requirements
- R1: After synchronous reset the bias output is bypass (code 0), the done flag is 0, no transition is in progress, and all three registers read 0.
- R2: Register address 0 (setup) holds the target class in bits 1:0 (1 fast, 2 nominal, 3 slow, 0 none). Bit 2 is the request bit. Bits 4:3 hold the read-only status (0 bypass, 1 reverse, 2 forward). Bit 6 is the read-only in-transition flag. All other bits read 0.
- R3: Register address 1 (control) holds the enable in bit 0, reverse-allowed in bit 1, forward-allowed in bit 2, sleep-reverse select in bit 3 and the wait count in bits 15:8. Bit 0 drives `ldo_en_o` and bit 3 drives `sleep_rev_o`.
- R4: On the clock edge that accepts a request, the bias output takes its new value. Fast with forward allowed gives forward (2). Slow with reverse allowed gives reverse (1). Every other combination gives bypass (0).
- R5: With a wait count N greater than 0, the done flag rises 8*N+1 cycles after the edge that accepts the request.
- R6: With a wait count of 0, the done flag rises on the cycle after the request.
- R7: The request bit and the in-transition flag read 1 from the accepting edge until the edge that sets done. On that edge the status field takes the bias value.
- R8: Register address 2 bit 0 is the sticky done flag, also driven on `done_o`. Writing a 1 there clears it. If a completion and a clear write fall on the same edge, the completion wins.
- R9: A request written while the enable bit is 0 is ignored. No transition starts and the bias output stays as it was (bypass after reset).
- R10: A request written during a transition is ignored. The running transition keeps its mode and its completion time.
- R11: The bias output does not change while a transition is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write register address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Read register address |
| rd_data | output | 32 | Read data (combinational from rd_addr) |
| bias_mode_o | output | 2 | Regulator mode: 0 bypass, 1 reverse, 2 forward |
| ldo_en_o | output | 1 | Regulator enable |
| sleep_rev_o | output | 1 | Reverse bias selected for sleep |
| done_o | output | 1 | Sticky transition-done flag |

## Verification
Requests are issued for each speed class, with and without the matching bias permission. This separates the three bias outputs from each other and shows that a missing permission falls back to bypass. Wait counts of 0, 1 and 2 tell the zero-wait shortcut apart from the eight-clock tick scaling, and measured cycle counts pin down an off-by-one in either. Requests made while the regulator is disabled or already busy, and a clear write that lands on the completion edge, exercise the ignore rules and the set-over-clear priority. A cycle-by-cycle model compares every register readback and output pin.

// File: rtl/bbias_pkg.sv
package bbias_pkg;

    localparam int DATA_W = 32;
    localparam int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] ADDR_SETUP = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_CTRL  = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_STAT  = 2'd2;

    // setup word bit positions
    localparam int SU_CLS_LSB  = 0;
    localparam int SU_REQ_BIT  = 2;
    localparam int SU_STS_LSB  = 3;
    localparam int SU_BUSY_BIT = 6;

    // control word bit positions
    localparam int CT_EN_BIT    = 0;
    localparam int CT_REV_BIT   = 1;
    localparam int CT_FWD_BIT   = 2;
    localparam int CT_SLEEP_BIT = 3;
    localparam int CT_WAIT_LSB  = 8;

    localparam int ST_DONE_BIT = 0;

    typedef enum logic [1:0] {
        BIAS_BYPASS  = 2'd0,
        BIAS_REVERSE = 2'd1,
        BIAS_FORWARD = 2'd2
    } bias_e;

    typedef enum logic [1:0] {
        CLS_NONE    = 2'd0,
        CLS_FAST    = 2'd1,
        CLS_NOMINAL = 2'd2,
        CLS_SLOW    = 2'd3
    } speed_e;

    typedef struct packed {
        logic sleep_rev;
        logic fwd_ok;
        logic rev_ok;
        logic en;
    } ctrl_flags_t;

    typedef enum logic {
        SEQ_IDLE   = 1'b0,
        SEQ_SETTLE = 1'b1
    } seq_state_e;

    function automatic bias_e pick_bias(speed_e cls, ctrl_flags_t fl);
        bias_e r;
        r = BIAS_BYPASS;
        if (cls == CLS_FAST && fl.fwd_ok)
            r = BIAS_FORWARD;
        else if (cls == CLS_SLOW && fl.rev_ok)
            r = BIAS_REVERSE;
        return r;
    endfunction

endpackage

// File: rtl/bbias_regs.sv
module bbias_regs
    import bbias_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int AW = ADDR_W,
    parameter int WAIT_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [DW-1:0]     wr_data,
    input  logic [AW-1:0]     rd_addr,
    input  logic              busy,
    input  bias_e             status,
    input  logic              done_set,
    output ctrl_flags_t       flags,
    output logic [WAIT_W-1:0] wait_cnt,
    output speed_e            cls_wr,
    output logic              req_wr,
    output logic              done,
    output logic [DW-1:0]     rd_data
);

    speed_e cls_q;
    logic   setup_wr, ctrl_wr, clr_wr;

    assign setup_wr = wr_en && (wr_addr == ADDR_SETUP);
    assign ctrl_wr  = wr_en && (wr_addr == ADDR_CTRL);
    assign clr_wr   = wr_en && (wr_addr == ADDR_STAT) && wr_data[ST_DONE_BIT];
    assign cls_wr   = speed_e'(wr_data[SU_CLS_LSB +: 2]);
    assign req_wr   = setup_wr && wr_data[SU_REQ_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            cls_q    <= CLS_NONE;
            flags    <= '0;
            wait_cnt <= '0;
            done     <= 1'b0;
        end else begin
            if (setup_wr)
                cls_q <= cls_wr;
            if (ctrl_wr) begin
                flags.en        <= wr_data[CT_EN_BIT];
                flags.rev_ok    <= wr_data[CT_REV_BIT];
                flags.fwd_ok    <= wr_data[CT_FWD_BIT];
                flags.sleep_rev <= wr_data[CT_SLEEP_BIT];
                wait_cnt        <= wr_data[CT_WAIT_LSB +: WAIT_W];
            end
            if (done_set)
                done <= 1'b1;
            else if (clr_wr)
                done <= 1'b0;
        end
    end

    always_comb begin
        rd_data = '0;
        unique case (rd_addr)
            ADDR_SETUP: begin
                rd_data[SU_CLS_LSB +: 2] = cls_q;
                rd_data[SU_REQ_BIT]      = busy;
                rd_data[SU_STS_LSB +: 2] = status;
                rd_data[SU_BUSY_BIT]     = busy;
            end
            ADDR_CTRL: begin
                rd_data[CT_EN_BIT]              = flags.en;
                rd_data[CT_REV_BIT]             = flags.rev_ok;
                rd_data[CT_FWD_BIT]             = flags.fwd_ok;
                rd_data[CT_SLEEP_BIT]           = flags.sleep_rev;
                rd_data[CT_WAIT_LSB +: WAIT_W]  = wait_cnt;
            end
            ADDR_STAT: rd_data[ST_DONE_BIT] = done;
            default:   rd_data = '0;
        endcase
    end

endmodule

// File: rtl/bbias_settle_timer.sv
module bbias_settle_timer #(
    parameter int WAIT_W   = 8,
    parameter int PRESCALE = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [WAIT_W-1:0] load_val,
    input  logic              run,
    output logic              expired
);

    localparam int PRE_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRESCALE - 1);

    logic [PRE_W-1:0]  pre_q;
    logic [WAIT_W-1:0] ticks_q;

    assign expired = (ticks_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            pre_q   <= '0;
            ticks_q <= '0;
        end else if (load) begin
            pre_q   <= '0;
            ticks_q <= load_val;
        end else if (run && !expired) begin
            if (pre_q == PRE_LAST) begin
                pre_q   <= '0;
                ticks_q <= ticks_q - 1'b1;
            end else begin
                pre_q <= pre_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/bbias_seq_fsm.sv
module bbias_seq_fsm
    import bbias_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        req_wr,
    input  speed_e      cls_wr,
    input  ctrl_flags_t flags,
    input  logic        expired,
    output logic        start,
    output logic        busy,
    output logic        done_set,
    output bias_e       bias,
    output bias_e       status
);

    seq_state_e state_q;

    assign busy     = (state_q == SEQ_SETTLE);
    assign start    = req_wr && flags.en && (state_q == SEQ_IDLE);
    assign done_set = busy && expired;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
            bias    <= BIAS_BYPASS;
            status  <= BIAS_BYPASS;
        end else begin
            unique case (state_q)
                SEQ_IDLE: if (start) begin
                    state_q <= SEQ_SETTLE;
                    bias    <= pick_bias(cls_wr, flags);
                end
                SEQ_SETTLE: if (expired) begin
                    state_q <= SEQ_IDLE;
                    status  <= bias;
                end
                default: state_q <= SEQ_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/bbias_seq_ctrl.sv
module bbias_seq_ctrl
    import bbias_pkg::*;
#(
    parameter int WAIT_W   = 8,
    parameter int PRESCALE = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic [1:0]        bias_mode_o,
    output logic              ldo_en_o,
    output logic              sleep_rev_o,
    output logic              done_o
);

    ctrl_flags_t       flags;
    logic [WAIT_W-1:0] wait_cnt;
    speed_e            cls_wr;
    logic              req_wr, start, busy, done_set, expired;
    bias_e             bias, status;

    bbias_regs #(.DW(DATA_W), .AW(ADDR_W), .WAIT_W(WAIT_W)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .busy(busy), .status(status), .done_set(done_set),
        .flags(flags), .wait_cnt(wait_cnt), .cls_wr(cls_wr), .req_wr(req_wr),
        .done(done_o), .rd_data(rd_data)
    );

    bbias_settle_timer #(.WAIT_W(WAIT_W), .PRESCALE(PRESCALE)) u_timer (
        .clk(clk), .rst(rst), .load(start), .load_val(wait_cnt),
        .run(busy), .expired(expired)
    );

    bbias_seq_fsm u_fsm (
        .clk(clk), .rst(rst), .req_wr(req_wr), .cls_wr(cls_wr), .flags(flags),
        .expired(expired), .start(start), .busy(busy), .done_set(done_set),
        .bias(bias), .status(status)
    );

    assign bias_mode_o = bias;
    assign ldo_en_o    = flags.en;
    assign sleep_rev_o = flags.sleep_rev;

endmodule

// File: rtl/bbias_seq_ctrl_chk.sv
module bbias_seq_ctrl_chk #(
    parameter int WAIT_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [1:0]        wr_addr,
    input logic [31:0]       wr_data,
    input logic              busy,
    input logic              start,
    input logic              fwd_ok,
    input logic [WAIT_W-1:0] wait_cnt,
    input logic [1:0]        bias_mode_o,
    input logic              ldo_en_o,
    input logic              done_o
);

    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
        done_o && !(wr_en && wr_addr == 2'd2 && wr_data[0]) |=> done_o); // R8

    AST_DISABLED_NO_START: assert property (@(posedge clk) disable iff (rst)
        !ldo_en_o && !busy |=> !busy); // R9

    AST_MODE_HELD: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(bias_mode_o)); // R11

    AST_ZERO_WAIT: assert property (@(posedge clk) disable iff (rst)
        start && wait_cnt == '0 |=> busy ##1 (!busy && done_o)); // R6

    AST_FALL_SETS_DONE: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done_o); // R7

    AST_FAST_FORWARD: assert property (@(posedge clk) disable iff (rst)
        start && wr_data[1:0] == 2'd1 && fwd_ok |=> bias_mode_o == 2'd2); // R4

endmodule

bind bbias_seq_ctrl bbias_seq_ctrl_chk #(.WAIT_W(WAIT_W)) u_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .busy(busy), .start(start), .fwd_ok(flags.fwd_ok), .wait_cnt(wait_cnt),
    .bias_mode_o(bias_mode_o), .ldo_en_o(ldo_en_o), .done_o(done_o)
);

// File: tb/bbias_seq_ctrl_tb.sv
module bbias_seq_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [1:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic [1:0]  bias_mode_o;
    logic        ldo_en_o, sleep_rev_o, done_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    bbias_seq_ctrl dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .bias_mode_o(bias_mode_o),
        .ldo_en_o(ldo_en_o), .sleep_rev_o(sleep_rev_o), .done_o(done_o)
    );

    // behavioural reference model
    int m_busy, m_cnt, m_mode, m_status, m_done, m_cls;
    int m_en, m_rev, m_fwd, m_sleep, m_wait;

    function automatic int model_target(int cls);
        if (cls == 1 && m_fwd != 0) return 2;
        if (cls == 3 && m_rev != 0) return 1;
        return 0;
    endfunction

    function automatic logic [31:0] model_read(logic [1:0] a);
        logic [31:0] v = '0;
        case (a)
            2'd0: begin
                v[1:0] = m_cls[1:0]; v[2] = m_busy[0];
                v[4:3] = m_status[1:0]; v[6] = m_busy[0];
            end
            2'd1: begin
                v[0] = m_en[0]; v[1] = m_rev[0]; v[2] = m_fwd[0];
                v[3] = m_sleep[0]; v[15:8] = m_wait[7:0];
            end
            2'd2: v[0] = m_done[0];
            default: v = '0;
        endcase
        return v;
    endfunction

    always @(posedge clk) begin
        bit st, fin;
        if (rst) begin
            m_busy = 0; m_cnt = 0; m_mode = 0; m_status = 0; m_done = 0; m_cls = 0;
            m_en = 0; m_rev = 0; m_fwd = 0; m_sleep = 0; m_wait = 0;
        end else begin
            st  = wr_en && wr_addr == 2'd0 && wr_data[2] && m_busy == 0 && m_en != 0;
            fin = 0;
            if (m_busy != 0) begin
                if (m_cnt == 0) begin
                    m_busy = 0; m_status = m_mode; m_done = 1; fin = 1;
                end else m_cnt--;
            end
            if (st) begin
                m_busy = 1; m_cnt = 8 * m_wait; m_mode = model_target(int'(wr_data[1:0]));
            end
            if (wr_en && wr_addr == 2'd0) m_cls = int'(wr_data[1:0]);
            if (wr_en && wr_addr == 2'd1) begin
                m_en = wr_data[0]; m_rev = wr_data[1]; m_fwd = wr_data[2];
                m_sleep = wr_data[3]; m_wait = int'(wr_data[15:8]);
            end
            if (wr_en && wr_addr == 2'd2 && wr_data[0] && !fin) m_done = 0;
        end
    end

    task automatic chk(string req, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst && !finished) begin
            chk("R4 bias output", int'(bias_mode_o), m_mode);
            chk("R8 done flag", int'(done_o), m_done);
            chk("R3 enable pin", int'(ldo_en_o), m_en);
            chk("R3 sleep pin", int'(sleep_rev_o), m_sleep);
            chk("R2 readback", int'(rd_data), int'(model_read(rd_addr)));
        end
    end

    task automatic wr(logic [1:0] a, logic [31:0] d);
        @(negedge clk); #2;
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk); #2;
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic rd(logic [1:0] a, output logic [31:0] d);
        @(negedge clk); #2;
        rd_addr = a; #1;
        d = rd_data;
        rd_addr = 2'd0;
    endtask

    task automatic wait_done(output int k);
        k = 0;
        while (!done_o && k < 5000) begin
            @(posedge clk); #1; k++;
        end
    endtask

    task automatic finish_run();
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end

    initial begin
        logic [31:0] d;
        int k;
        repeat (3) @(posedge clk);
        @(negedge clk); #2; rst = 1'b0;

        // R1 reset state
        chk("R1 bias after reset", int'(bias_mode_o), 0);
        rd(2'd0, d); chk("R1 setup reads 0", int'(d), 0);
        rd(2'd1, d); chk("R1 ctrl reads 0", int'(d), 0);
        rd(2'd2, d); chk("R1 done reads 0", int'(d), 0);

        // R9 request while disabled
        wr(2'd0, 32'h5);
        rd(2'd0, d); chk("R9 no transition when disabled", int'(d[6]), 0);
        chk("R9 bias stays bypass", int'(bias_mode_o), 0);
        chk("R9 no done", int'(done_o), 0);

        // R6 fast + forward, wait 0
        wr(2'd1, 32'h0000_000F);
        rd(2'd1, d); chk("R3 ctrl readback", int'(d), 32'hF);
        wr(2'd0, 32'h5);
        wait_done(k);
        chk("R6 zero wait cycles", k, 1);
        chk("R4 fast gives forward", int'(bias_mode_o), 2);
        rd(2'd0, d); chk("R7 status forward", int'(d[4:3]), 2);
        chk("R7 request bit cleared", int'(d[2]), 0);
        wr(2'd2, 32'h1);
        chk("R8 write-one clears", int'(done_o), 0);

        // R5 slow + reverse, wait 2, with R10 request during transition
        wr(2'd1, 32'h0000_0207);
        wr(2'd0, 32'h7);
        rd(2'd0, d); chk("R7 busy during settle", int'(d[6]), 1);
        chk("R7 request bit held", int'(d[2]), 1);
        wr(2'd0, 32'h6);
        chk("R10 mode kept", int'(bias_mode_o), 1);
        wait_done(k);
        chk("R5 total wait cycles", k + 3, 17);
        rd(2'd0, d); chk("R7 status reverse", int'(d[4:3]), 1);
        wr(2'd2, 32'h1);

        // R5 nominal, wait 1
        wr(2'd1, 32'h0000_0107);
        wr(2'd0, 32'h6);
        chk("R4 nominal gives bypass", int'(bias_mode_o), 0);
        wait_done(k);
        chk("R5 wait 1 cycles", k, 9);
        wr(2'd2, 32'h1);

        // R4 fast without forward permission
        wr(2'd1, 32'h0000_0003);
        wr(2'd0, 32'h5);
        chk("R4 fast without permission is bypass", int'(bias_mode_o), 0);
        wait_done(k);
        chk("R6 done after disallowed fast", k, 1);
        wr(2'd2, 32'h1);

        // R8 completion wins over same-edge clear
        wr(2'd1, 32'h0000_0005);
        @(negedge clk); #2;
        wr_en = 1'b1; wr_addr = 2'd0; wr_data = 32'h5;
        @(negedge clk); #2;
        wr_addr = 2'd2; wr_data = 32'h1;
        @(negedge clk); #2;
        wr_en = 1'b0; wr_data = '0;
        chk("R8 set beats clear", int'(done_o), 1);

        // R3 disable and sleep select pins
        wr(2'd1, 32'h0000_0008);
        chk("R3 enable low", int'(ldo_en_o), 0);
        chk("R3 sleep reverse pin", int'(sleep_rev_o), 1);

        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule